// File: doc/BRIEF.md
# Tag-Renaming Out-of-Order Issue Engine

This block accepts instructions in program order from an operation queue and runs them out of order across two groups of waiting slots: one group for add and subtract, one for multiply and divide. Each slot has a small tag. When an instruction is accepted, each source register is replaced by its current value, or by the tag of the slot that will produce it. The destination register is then marked as pending on the new slot's tag. This renaming removes write-after-read and write-after-write ordering. The only dependences left are true data dependences.

A slot starts its countdown execution model once both operands are present. When the countdown ends, the slot requests the shared result bus, which carries a result value together with the producer's tag. In the cycle of a broadcast, every waiting slot and every register still waiting on that tag takes the value. The producing slot is freed. Only one result is broadcast per cycle. If several slots finish together, the one accepted earliest wins. A debug read port shows any register's value and whether it is pending.

Top module: `rsr_engine`

## Requirements
- R1: After reset, register i holds 3*i+1 and is not pending, the result bus is idle, and `iq_ready` is high.
- R2: Operation codes are 0 add, 1 subtract, 2 multiply and 3 divide. Results are taken modulo 2^DATA_W, and a divide by zero gives all ones. Add-group slots carry tags 1..3 and multiply-group slots carry tags 4..5. The lowest free slot of the group is taken, and its tag appears on `iss_tag`.
- R3: If no slot of the needed group is free, `iq_ready` is low and the head instruction is not consumed.
- R4: At acceptance, each source takes the register value when the register is not pending, and otherwise takes the pending tag. The destination then becomes pending (`rd_pend` high).
- R5: A slot starts executing only when both of its producer tags are zero. An instruction whose operands are ready at acceptance edge E broadcasts after edge E+L, where L is 2 for add/subtract, 10 for multiply and 40 for divide.
- R6: A broadcast carries a nonzero tag and the result. Matching slots and matching registers capture the result and clear their tags. The producing slot is free in the next cycle.
- R7: A newer writer of a register replaces its pending tag. The older result then no longer changes that register.
- R8: At most one result is broadcast per cycle. Among finished slots, the one accepted earliest broadcasts first, and the others wait.
- R9: A source whose producer broadcasts in the cycle of acceptance takes the broadcast value directly and needs no later wakeup.
- R10: `rd_data`/`rd_pend` show the addressed register's value and pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iq_valid | input | 1 | Head of the operation queue is valid |
| iq_op | input | 2 | Operation code |
| iq_dst | input | REG_W | Destination register |
| iq_src1 | input | REG_W | First source register |
| iq_src2 | input | REG_W | Second source register |
| iq_ready | output | 1 | Head can be accepted this cycle |
| iss_tag | output | TAG_W | Tag of the slot taking the head |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TAG_W | Producer tag on the result bus |
| cdb_data | output | DATA_W | Result value on the result bus |
| rd_addr | input | REG_W | Debug read register |
| rd_data | output | DATA_W | Debug read value |
| rd_pend | output | 1 | Debug read register is pending |

## Verification
The engine is tried first with isolated single instructions, which expose each latency and the tag numbering. Next come two independent instructions timed to finish in the same cycle, which tells the oldest-first arbitration apart from any other order. A producer–consumer pair is then spaced so that the consumer is accepted during the producer's broadcast, which separates the direct capture at acceptance from a lost wakeup. Finally, a write-after-write sequence, a full adder group behind a long divide, and a pseudo-random stream are each compared, broadcast by broadcast, against an in-order model of the results.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rsr_op_e;
endpackage

// File: rtl/rsr_regfile.sv
module rsr_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int TAG_W  = 4,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  s1_addr,
    input  logic [REG_W-1:0]  s2_addr,
    input  logic [REG_W-1:0]  dbg_addr,
    output logic [DATA_W-1:0] s1_val,
    output logic [TAG_W-1:0]  s1_tag,
    output logic [DATA_W-1:0] s2_val,
    output logic [TAG_W-1:0]  s2_tag,
    output logic [DATA_W-1:0] dbg_val,
    output logic              dbg_pend,
    input  logic              ren_en,
    input  logic [REG_W-1:0]  ren_addr,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] val;
        logic [NREG-1:0][TAG_W-1:0]  tag;
    } rf_t;

    rf_t rf_q, rf_d;

    always_comb begin
        rf_d = rf_q;
        for (int r = 0; r < NREG; r++) begin
            if (cdb_valid && rf_q.tag[r] == cdb_tag) begin
                rf_d.val[r] = cdb_data;
                rf_d.tag[r] = '0;
            end
        end
        if (ren_en) rf_d.tag[ren_addr] = ren_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                rf_q.val[r] <= DATA_W'(3 * r + 1);
                rf_q.tag[r] <= '0;
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    assign s1_val   = rf_q.val[s1_addr];
    assign s1_tag   = rf_q.tag[s1_addr];
    assign s2_val   = rf_q.val[s2_addr];
    assign s2_tag   = rf_q.tag[s2_addr];
    assign dbg_val  = rf_q.val[dbg_addr];
    assign dbg_pend = rf_q.tag[dbg_addr] != '0;

    for (genvar gr = 0; gr < NREG; gr++) begin : g_reg_chk
        // R6
        reg_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && rf_q.tag[gr] == cdb_tag) |=> (rf_q.tag[gr] != $past(cdb_tag)));
    end
endmodule

// File: rtl/rsr_age_arb.sv
module rsr_age_arb #(
    parameter int NS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] alloc_v,
    input  logic [NS-1:0] busy_v,
    input  logic [NS-1:0] req_v,
    output logic [NS-1:0] grant_v
);
    typedef struct packed {
        logic [NS-1:0][NS-1:0] older;
    } age_t;

    age_t age_q, age_d;

    always_comb begin
        age_d = age_q;
        for (int j = 0; j < NS; j++) begin
            if (alloc_v[j]) begin
                for (int i = 0; i < NS; i++) begin
                    age_d.older[i][j] = busy_v[i];
                    age_d.older[j][i] = 1'b0;
                end
            end
        end
        for (int i = 0; i < NS; i++) begin
            grant_v[i] = req_v[i];
            for (int j = 0; j < NS; j++) begin
                if (j != i && req_v[j] && age_q.older[j][i]) grant_v[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_v));
    // R3
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_v & busy_v) == '0);
endmodule

// File: rtl/rsr_engine.sv
module rsr_engine
    import rsr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NREG    = 8,
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int TAG_W   = 4,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40,
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iq_valid,
    input  logic [1:0]        iq_op,
    input  logic [REG_W-1:0]  iq_dst,
    input  logic [REG_W-1:0]  iq_src1,
    input  logic [REG_W-1:0]  iq_src2,
    output logic              iq_ready,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              cdb_valid,
    output logic [TAG_W-1:0]  cdb_tag,
    output logic [DATA_W-1:0] cdb_data,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_pend
);
    localparam int NS    = N_ADD + N_MUL;
    localparam int IDX_W = (NS > 1) ? $clog2(NS) : 1;
    localparam int CNT_W = $clog2(LAT_DIV + 1);

    typedef struct packed {
        logic              busy;
        logic              exec;
        rsr_op_e           op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
        logic [CNT_W-1:0]  cnt;
    } stn_t;

    typedef struct packed {
        stn_t [NS-1:0] stn;
    } state_t;

    state_t st_q, st_d;

    logic [NS-1:0]     busy_v, req_v, grant_v, alloc_v;
    logic              add_any, mul_any, issue;
    logic [IDX_W-1:0]  add_idx, mul_idx, alloc_idx, cdb_idx;
    logic [DATA_W-1:0] s1_val, s2_val;
    logic [TAG_W-1:0]  s1_tag, s2_tag;

    function automatic logic [DATA_W-1:0] alu(rsr_op_e op, logic [DATA_W-1:0] a,
                                              logic [DATA_W-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return a * b;
            default: return (b == '0) ? '1 : a / b;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] lat_of(rsr_op_e op);
        case (op)
            OP_MUL:  return CNT_W'(LAT_MUL - 1);
            OP_DIV:  return CNT_W'(LAT_DIV - 1);
            default: return CNT_W'(LAT_ADD - 1);
        endcase
    endfunction

    // slot selection, acceptance and result bus drive
    always_comb begin
        add_any = 1'b0;
        add_idx = '0;
        for (int i = N_ADD - 1; i >= 0; i--) begin
            if (!st_q.stn[i].busy) begin
                add_any = 1'b1;
                add_idx = IDX_W'(i);
            end
        end
        mul_any = 1'b0;
        mul_idx = '0;
        for (int i = NS - 1; i >= N_ADD; i--) begin
            if (!st_q.stn[i].busy) begin
                mul_any = 1'b1;
                mul_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < NS; i++) begin
            busy_v[i] = st_q.stn[i].busy;
            req_v[i]  = st_q.stn[i].busy && st_q.stn[i].exec && st_q.stn[i].cnt == '0;
        end
        iq_ready  = iq_op[1] ? mul_any : add_any;
        issue     = iq_valid && iq_ready;
        alloc_idx = iq_op[1] ? mul_idx : add_idx;
        alloc_v   = issue ? (NS'(1) << alloc_idx) : '0;
        iss_tag   = TAG_W'(alloc_idx) + TAG_W'(1);
        cdb_valid = |grant_v;
        cdb_idx   = '0;
        for (int i = 0; i < NS; i++) begin
            if (grant_v[i]) cdb_idx = IDX_W'(i);
        end
        cdb_tag  = cdb_valid ? TAG_W'(cdb_idx) + TAG_W'(1) : '0;
        cdb_data = alu(st_q.stn[cdb_idx].op, st_q.stn[cdb_idx].vj, st_q.stn[cdb_idx].vk);
    end

    // next state of every slot
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NS; i++) begin
            if (grant_v[i]) begin
                st_d.stn[i].busy = 1'b0;
                st_d.stn[i].exec = 1'b0;
            end else if (st_q.stn[i].busy) begin
                if (!st_q.stn[i].exec) begin
                    if (st_q.stn[i].qj == '0 && st_q.stn[i].qk == '0) begin
                        st_d.stn[i].exec = 1'b1;
                        st_d.stn[i].cnt  = lat_of(st_q.stn[i].op);
                    end else begin
                        if (st_q.stn[i].qj != '0 && cdb_valid && st_q.stn[i].qj == cdb_tag) begin
                            st_d.stn[i].vj = cdb_data;
                            st_d.stn[i].qj = '0;
                        end
                        if (st_q.stn[i].qk != '0 && cdb_valid && st_q.stn[i].qk == cdb_tag) begin
                            st_d.stn[i].vk = cdb_data;
                            st_d.stn[i].qk = '0;
                        end
                    end
                end else if (st_q.stn[i].cnt != '0) begin
                    st_d.stn[i].cnt = st_q.stn[i].cnt - CNT_W'(1);
                end
            end
            if (alloc_v[i]) begin
                st_d.stn[i].busy = 1'b1;
                st_d.stn[i].exec = 1'b0;
                st_d.stn[i].op   = rsr_op_e'(iq_op);
                st_d.stn[i].cnt  = '0;
                if (s1_tag == '0) begin
                    st_d.stn[i].vj = s1_val;
                    st_d.stn[i].qj = '0;
                end else if (cdb_valid && cdb_tag == s1_tag) begin
                    st_d.stn[i].vj = cdb_data;
                    st_d.stn[i].qj = '0;
                end else begin
                    st_d.stn[i].vj = '0;
                    st_d.stn[i].qj = s1_tag;
                end
                if (s2_tag == '0) begin
                    st_d.stn[i].vk = s2_val;
                    st_d.stn[i].qk = '0;
                end else if (cdb_valid && cdb_tag == s2_tag) begin
                    st_d.stn[i].vk = cdb_data;
                    st_d.stn[i].qk = '0;
                end else begin
                    st_d.stn[i].vk = '0;
                    st_d.stn[i].qk = s2_tag;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rsr_regfile #(.DATA_W(DATA_W), .NREG(NREG), .TAG_W(TAG_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .s1_addr(iq_src1), .s2_addr(iq_src2), .dbg_addr(rd_addr),
        .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
        .dbg_val(rd_data), .dbg_pend(rd_pend),
        .ren_en(issue), .ren_addr(iq_dst), .ren_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
    );

    rsr_age_arb #(.NS(NS)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .alloc_v(alloc_v), .busy_v(busy_v), .req_v(req_v), .grant_v(grant_v)
    );

    // R6
    cdb_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TAG_W'(NS)));

    for (genvar gi = 0; gi < NS; gi++) begin : g_stn_chk
        // R5
        exec_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.stn[gi].exec |-> (st_q.stn[gi].qj == '0 && st_q.stn[gi].qk == '0));
        // R5
        no_early_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.stn[gi].busy && !st_q.stn[gi].exec &&
             (st_q.stn[gi].qj != '0 || st_q.stn[gi].qk != '0)) |=> !st_q.stn[gi].exec);
        // R6
        rs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_v[gi] |=> !st_q.stn[gi].busy);
    end
endmodule

// File: tb/tb_rsr_engine.sv
module tb_rsr_engine;
    localparam int DW = 16;
    localparam int NR = 8;
    localparam int RW = 3;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iq_valid = 1'b0;
    logic [1:0]    iq_op = 2'd0;
    logic [RW-1:0] iq_dst = '0, iq_src1 = '0, iq_src2 = '0;
    logic          iq_ready;
    logic [TW-1:0] iss_tag;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [DW-1:0] cdb_data;
    logic [RW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_pend;

    rsr_engine dut (
        .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid), .iq_op(iq_op),
        .iq_dst(iq_dst), .iq_src1(iq_src1), .iq_src2(iq_src2),
        .iq_ready(iq_ready), .iss_tag(iss_tag), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_data(cdb_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_pend(rd_pend)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, npend = 0;
    logic [DW-1:0] arch [NR];
    logic [DW-1:0] texp [16];
    bit            tpend [16];
    int            tiss [16], tlat [16], tbc [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_op(input logic [1:0] op, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a * b;
            default: return (b == 0) ? 16'hFFFF : a / b;
        endcase
    endfunction

    function automatic int lat_of(input logic [1:0] op);
        return (op == 2'd2) ? 10 : (op == 2'd3) ? 40 : 2;
    endfunction

    // per-clock comparison of every broadcast against the in-order model (R6)
    always @(negedge clk) begin
        if (rst_n && cdb_valid) begin
            chk(tpend[cdb_tag], "R6 broadcast tag outstanding", int'(tpend[cdb_tag]), 1);
            chk(cdb_data == texp[cdb_tag], "R6 broadcast data", cdb_data, texp[cdb_tag]);
            if (tlat[cdb_tag] > 0)
                chk(cyc == tiss[cdb_tag] + tlat[cdb_tag], "R5/R9 broadcast cycle",
                    cyc - tiss[cdb_tag], tlat[cdb_tag]);
            tbc[cdb_tag] = cyc;
            tpend[cdb_tag] = 1'b0;
            npend--;
        end
    end

    task automatic issue(input logic [1:0] op, input int d, input int a, input int b,
                         input bit lchk, output int tag);
        logic [DW-1:0] res;
        @(negedge clk);
        iq_valid = 1'b1;
        iq_op = op;
        iq_dst = RW'(d);
        iq_src1 = RW'(a);
        iq_src2 = RW'(b);
        #1;
        while (!iq_ready) begin
            @(negedge clk);
            #1;
        end
        tag = int'(iss_tag);
        @(posedge clk);
        #1;
        iq_valid = 1'b0;
        res = ref_op(op, arch[a], arch[b]);
        arch[d] = res;
        texp[tag] = res;
        tpend[tag] = 1'b1;
        tiss[tag] = cyc;
        tlat[tag] = lchk ? lat_of(op) : 0;
        npend++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_idle();
        while (npend != 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t, tm, ta, tb;
        logic [15:0] lf;
        for (int r = 0; r < NR; r++) arch[r] = DW'(3 * r + 1);
        for (int k = 0; k < 16; k++) begin
            tpend[k] = 0; tlat[k] = 0; tbc[k] = 0; tiss[k] = 0; texp[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(iq_ready == 1'b1, "R1 iq_ready", iq_ready, 1);
        chk(cdb_valid == 1'b0, "R1 bus idle", cdb_valid, 0);
        for (int r = 0; r < NR; r++) begin
            rd_addr = RW'(r);
            #1;
            chk(rd_data == DW'(3 * r + 1) && !rd_pend, "R1 register reset", rd_data, 3 * r + 1);
        end

        // R2/R5 isolated latencies and tag numbering
        issue(2'd0, 1, 2, 3, 1'b1, t);
        chk(t == 1, "R2 first add tag", t, 1);
        wait_idle();
        issue(2'd2, 2, 1, 3, 1'b1, t);
        chk(t == 4, "R2 first mul tag", t, 4);
        wait_idle();
        issue(2'd3, 3, 2, 1, 1'b1, t);
        wait_idle();
        issue(2'd1, 7, 4, 4, 1'b1, t);
        wait_idle();
        issue(2'd3, 6, 1, 7, 1'b1, t);   // R2 divide by zero
        wait_idle();
        rd_addr = 3'd6;
        #1;
        chk(rd_data == 16'hFFFF, "R2 divide by zero", rd_data, 16'hFFFF);

        // R8 simultaneous finish: older multiply wins
        issue(2'd2, 1, 2, 3, 1'b0, tm);
        idle(7);
        issue(2'd0, 4, 5, 6, 1'b0, ta);
        wait_idle();
        chk(tbc[tm] < tbc[ta], "R8 oldest first", tbc[ta] - tbc[tm], 1);
        chk(tbc[ta] == tbc[tm] + 1, "R8 loser waits one cycle", tbc[ta] - tbc[tm], 1);

        // R9 consumer accepted during producer broadcast
        issue(2'd0, 2, 0, 1, 1'b0, ta);
        idle(2);
        issue(2'd0, 3, 2, 2, 1'b1, tb);
        wait_idle();

        // R4/R7 renaming and write-after-write
        issue(2'd2, 6, 1, 2, 1'b0, tm);
        rd_addr = 3'd6;
        #1;
        chk(rd_pend == 1'b1, "R4 destination pending", rd_pend, 1);
        issue(2'd0, 0, 6, 1, 1'b0, t);
        issue(2'd0, 6, 2, 3, 1'b0, ta);
        wait_idle();
        rd_addr = 3'd6;
        #1;
        chk(rd_data == arch[6], "R7 newer writer kept", rd_data, arch[6]);
        rd_addr = 3'd0;
        #1;
        chk(rd_data == arch[0], "R4 reader of older writer", rd_data, arch[0]);

        // R3 full adder group behind a long divide
        issue(2'd3, 7, 1, 2, 1'b0, t);
        issue(2'd0, 0, 7, 1, 1'b0, t);
        issue(2'd0, 3, 7, 2, 1'b0, t);
        issue(2'd0, 4, 7, 7, 1'b0, t);
        @(negedge clk);
        iq_valid = 1'b1;
        iq_op = 2'd0;
        iq_dst = 3'd5; iq_src1 = 3'd0; iq_src2 = 3'd1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(iq_ready == 1'b0, "R3 stall when adders full", iq_ready, 0);
            @(negedge clk);
        end
        iq_valid = 1'b0;
        issue(2'd0, 5, 0, 1, 1'b0, t);
        wait_idle();

        // pseudo-random stream
        lf = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            logic [1:0] op;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op = lf[1:0];
            if (op == 2'd3 && lf[5]) op = 2'd2;
            issue(op, int'(lf[4:2]), int'(lf[8:6]), int'(lf[11:9]), 1'b0, t);
        end
        wait_idle();

        // R10 final register contents against in-order model
        for (int r = 0; r < NR; r++) begin
            rd_addr = RW'(r);
            #1;
            chk(rd_data == arch[r] && !rd_pend, "R10 final register", rd_data, arch[r]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule